// File: doc/BRIEF.md
# Early Direct-Branch Resolver

This block sits inside an instruction decode stage. It watches the group of instructions that decode forwards in one cycle and finds the control-flow errors that can be found before execution. For every direct, unconditional, PC-relative jump it works out the real target and writes it as the instruction's next PC. It then compares that target with the next PC the front end predicted. It also catches an instruction that was predicted taken but is not a control transfer at all.

Each hardware thread can have at most one mispredicting instruction per cycle, and the earliest one in slot order is chosen. For that instruction the block raises a redirect for fetch, drops the later slots of the same thread, and asks for that thread's pending queue and skid buffer to be flushed. In the fetch group that is arriving in the same cycle, it marks every instruction of that thread whose sequence number is younger than the mispredicting one. Each thread has a small state machine with four states: RUN, BLOCKED, UNBLOCKING and SQUASHING. It follows the stall and skid-buffer inputs from the surrounding decode control. When a squash finds the thread in BLOCKED or UNBLOCKING, the block also sends fetch an unblock. Three counters give the number of resolved jumps, jump mispredictions and control mispredictions.

Resolution and redirect generation are combinational within the cycle. Only the per-thread state and the counters are registered.

Top module: `early_branch_resolver`

## Requirements
- R1: After reset every thread state reads RUN (encoding 0), all three counters read zero, and no redirect, flush, unblock or fetch kill is raised while the inputs are idle.
- R2: A valid slot that is a control, direct and unconditional instruction is resolved. Its `out_npc` is pc + (sign-extended `dec_disp` × 4). A slot that is predicted taken but not a control instruction gets `out_npc` = pc + 4. Any other slot gets its predicted next PC: `dec_ptarg` if predicted taken, otherwise pc + 4.
- R3: A resolved slot whose target differs from its predicted next PC is a jump misprediction. The redirect for its thread carries `rd_seq` = the slot's sequence number, `rd_npc` = the computed target and `rd_ctl_mis` = 0.
- R4: `rd_taken` is 1 exactly when `rd_npc` differs from the mispredicting instruction's pc + 4.
- R5: A valid slot with `dec_ptaken`=1 and `dec_ctrl`=0 is a control misprediction. Its redirect has `rd_npc` = pc + 4, `rd_taken` = 0 and `rd_ctl_mis` = 1.
- R6: Only the lowest-numbered mispredicting slot of a thread produces the redirect. That slot is still forwarded. Every later valid slot of the same thread has `out_vld`=0, and slots of other threads are unaffected.
- R7: `fq_kill[k]` is 1 when fetch slot k is valid, its thread has a redirect this cycle, and (`fq_seq` − `rd_seq`) taken as a 16-bit signed value is greater than zero, so sequence wraparound is handled. Older, equal and other-thread entries are not killed.
- R8: `thr_flush[t]` is 1 in exactly the cycles where thread t has a redirect.
- R9: A redirect on thread t raises `thr_unblock[t]` when that thread's state is BLOCKED (1) or UNBLOCKING (2). The state becomes SQUASHING (3) on the next edge, taking priority over all other transitions.
- R10: Without a redirect, the state machine moves as follows.
  - RUN: stall leads to BLOCKED; otherwise it stays in RUN.
  - BLOCKED: stall keeps it in BLOCKED. Without stall it goes to RUN if the skid buffer is empty, otherwise to UNBLOCKING.
  - UNBLOCKING: stall leads to BLOCKED. Without stall it goes to RUN if the skid buffer is empty, otherwise it stays in UNBLOCKING.
  - SQUASHING: stall leads to BLOCKED; otherwise it goes to RUN.
- R11: On each edge `cnt_resolved` grows by the number of forwarded resolved slots. `cnt_brmis` grows by the number of threads with a jump-misprediction redirect, and `cnt_ctlmis` by the number with a control-misprediction redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_vld | input | W | Decode slot valid |
| dec_tid | input | W×TIDW | Thread of each slot |
| dec_seq | input | W×SEQW | Sequence number of each slot |
| dec_pc | input | W×PCW | PC of each slot |
| dec_ctrl | input | W | Slot is a control transfer |
| dec_direct | input | W | Slot target is PC-relative |
| dec_uncond | input | W | Slot is unconditional |
| dec_ptaken | input | W | Front end predicted taken |
| dec_ptarg | input | W×PCW | Predicted target |
| dec_disp | input | W×DISPW | Signed word displacement |
| fq_vld | input | FW | Incoming fetch slot valid |
| fq_tid | input | FW×TIDW | Thread of fetch slot |
| fq_seq | input | FW×SEQW | Sequence number of fetch slot |
| thr_stall | input | NTHR | Stall request per thread |
| thr_skid_empty | input | NTHR | Skid buffer empty per thread |
| out_vld | output | W | Slot forwarded |
| out_npc | output | W×PCW | Corrected next PC per slot |
| rd_vld | output | NTHR | Squash redirect (mispredict, prediction wrong, squash) |
| rd_ctl_mis | output | NTHR | Redirect is a control misprediction |
| rd_seq | output | NTHR×SEQW | Sequence number of the mispredicting instruction |
| rd_npc | output | NTHR×PCW | Corrected next PC for fetch |
| rd_taken | output | NTHR | Corrected path is taken |
| fq_kill | output | FW | Fetch slot is marked squashed |
| thr_flush | output | NTHR | Flush pending queue and skid buffer |
| thr_unblock | output | NTHR | Unblock sent to fetch |
| thr_state | output | NTHR×2 | Thread state |
| cnt_resolved | output | CNTW | Resolved jump count |
| cnt_brmis | output | CNTW | Jump misprediction count |
| cnt_ctlmis | output | CNTW | Control misprediction count |

## Verification
The first phase drives only correctly predicted jumps. The resolution arithmetic can then be checked with negative and positive displacements while no redirect may fire. The random phase mixes jumps with wrong targets, jumps predicted not taken, and non-control instructions predicted taken. It also includes conditional and indirect transfers that must pass untouched. Together these separate the two misprediction kinds and the taken-bit rule, and expose wrong slot priority when two mispredictions of one thread share a group.

Sequence numbers start just below the 16-bit wrap point, so fetch entries on both sides of zero test the signed-difference kill rule. Stall and skid-empty inputs toggle throughout, so squashes reach threads in every state, which tells the unblock rule apart from the plain state transitions.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_BLOCKED = 2'd1,
        ST_UNBLK   = 2'd2,
        ST_SQUASH  = 2'd3
    } thr_state_e;
endpackage

// File: rtl/ebr_slot_eval.sv
module ebr_slot_eval #(
    parameter int PCW   = 32,
    parameter int DISPW = 16
) (
    input  logic [PCW-1:0]   pc,
    input  logic             ctrl,
    input  logic             direct,
    input  logic             uncond,
    input  logic             ptaken,
    input  logic [PCW-1:0]   ptarg,
    input  logic [DISPW-1:0] disp,
    output logic             resolved,
    output logic [PCW-1:0]   npc,
    output logic             br_mis,
    output logic             ctl_mis
);
    localparam int EXTW = PCW - DISPW;

    logic [PCW-1:0] fall_thru;
    logic [PCW-1:0] disp_ext;
    logic [PCW-1:0] target;
    logic [PCW-1:0] pred_npc;

    always_comb begin
        fall_thru = pc + PCW'(4);
        disp_ext  = {{EXTW{disp[DISPW-1]}}, disp};
        target    = pc + (disp_ext << 2);
        pred_npc  = ptaken ? ptarg : fall_thru;
        resolved  = ctrl & direct & uncond;
        ctl_mis   = ptaken & ~ctrl;
        br_mis    = resolved & (target != pred_npc);
        if (resolved)
            npc = target;
        else if (ctl_mis)
            npc = fall_thru;
        else
            npc = pred_npc;
    end
endmodule

// File: rtl/ebr_fetch_kill.sv
module ebr_fetch_kill #(
    parameter int FW   = 4,
    parameter int NTHR = 2,
    parameter int TIDW = 1,
    parameter int SEQW = 16
) (
    input  logic [FW-1:0]              fq_vld,
    input  logic [FW-1:0][TIDW-1:0]    fq_tid,
    input  logic [FW-1:0][SEQW-1:0]    fq_seq,
    input  logic [NTHR-1:0]            rd_vld,
    input  logic [NTHR-1:0][SEQW-1:0]  rd_seq,
    output logic [FW-1:0]              fq_kill
);
    for (genvar k = 0; k < FW; k++) begin : g_kill
        logic [SEQW-1:0] diff;
        logic            younger;
        logic            hit_thr;
        always_comb begin
            hit_thr = 1'b0;
            diff    = '0;
            for (int t = 0; t < NTHR; t++) begin
                if (fq_tid[k] == TIDW'(t)) begin
                    hit_thr = rd_vld[t];
                    diff    = fq_seq[k] - rd_seq[t];
                end
            end
            younger    = ~diff[SEQW-1] && (diff != '0);
            fq_kill[k] = fq_vld[k] & hit_thr & younger;
        end
    end
endmodule

// File: rtl/ebr_thread_ctl.sv
module ebr_thread_ctl
    import ebr_pkg::*;
#(
    parameter int W    = 4,
    parameter int PCW  = 32,
    parameter int SEQW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              hit,
    input  logic [W-1:0]              hit_ctl,
    input  logic [W-1:0][SEQW-1:0]    seq,
    input  logic [W-1:0][PCW-1:0]     pc,
    input  logic [W-1:0][PCW-1:0]     npc,
    input  logic                      stall,
    input  logic                      skid_empty,
    output logic                      rd_vld,
    output logic                      rd_ctl_mis,
    output logic [SEQW-1:0]           rd_seq,
    output logic [PCW-1:0]            rd_npc,
    output logic                      rd_taken,
    output logic                      flush,
    output logic                      unblock,
    output logic [1:0]                state
);
    thr_state_e     st_q, st_d;
    logic [PCW-1:0] sel_pc;

    // earliest mispredicting slot of this thread
    always_comb begin
        rd_vld     = 1'b0;
        rd_ctl_mis = 1'b0;
        rd_seq     = '0;
        rd_npc     = '0;
        sel_pc     = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (hit[i]) begin
                rd_vld     = 1'b1;
                rd_ctl_mis = hit_ctl[i];
                rd_seq     = seq[i];
                rd_npc     = npc[i];
                sel_pc     = pc[i];
            end
        end
        rd_taken = rd_vld && (rd_npc != sel_pc + PCW'(4));
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:     st_d = stall ? ST_BLOCKED : ST_RUN;
            ST_BLOCKED: st_d = stall ? ST_BLOCKED : (skid_empty ? ST_RUN : ST_UNBLK);
            ST_UNBLK:   st_d = stall ? ST_BLOCKED : (skid_empty ? ST_RUN : ST_UNBLK);
            ST_SQUASH:  st_d = stall ? ST_BLOCKED : ST_RUN;
        endcase
        if (rd_vld)
            st_d = ST_SQUASH;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    // outputs
    always_comb begin
        flush   = rd_vld;
        unblock = 1'b0;
        unique case (st_q)
            ST_BLOCKED, ST_UNBLK: unblock = rd_vld;
            default:              unblock = 1'b0;
        endcase
        state = st_q;
    end
endmodule

// File: rtl/early_branch_resolver.sv
module early_branch_resolver #(
    parameter int W     = 4,
    parameter int FW    = 4,
    parameter int NTHR  = 2,
    parameter int PCW   = 32,
    parameter int SEQW  = 16,
    parameter int DISPW = 16,
    parameter int CNTW  = 16,
    parameter int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              dec_vld,
    input  logic [W-1:0][TIDW-1:0]    dec_tid,
    input  logic [W-1:0][SEQW-1:0]    dec_seq,
    input  logic [W-1:0][PCW-1:0]     dec_pc,
    input  logic [W-1:0]              dec_ctrl,
    input  logic [W-1:0]              dec_direct,
    input  logic [W-1:0]              dec_uncond,
    input  logic [W-1:0]              dec_ptaken,
    input  logic [W-1:0][PCW-1:0]     dec_ptarg,
    input  logic [W-1:0][DISPW-1:0]   dec_disp,
    input  logic [FW-1:0]             fq_vld,
    input  logic [FW-1:0][TIDW-1:0]   fq_tid,
    input  logic [FW-1:0][SEQW-1:0]   fq_seq,
    input  logic [NTHR-1:0]           thr_stall,
    input  logic [NTHR-1:0]           thr_skid_empty,
    output logic [W-1:0]              out_vld,
    output logic [W-1:0][PCW-1:0]     out_npc,
    output logic [NTHR-1:0]           rd_vld,
    output logic [NTHR-1:0]           rd_ctl_mis,
    output logic [NTHR-1:0][SEQW-1:0] rd_seq,
    output logic [NTHR-1:0][PCW-1:0]  rd_npc,
    output logic [NTHR-1:0]           rd_taken,
    output logic [FW-1:0]             fq_kill,
    output logic [NTHR-1:0]           thr_flush,
    output logic [NTHR-1:0]           thr_unblock,
    output logic [NTHR-1:0][1:0]      thr_state,
    output logic [CNTW-1:0]           cnt_resolved,
    output logic [CNTW-1:0]           cnt_brmis,
    output logic [CNTW-1:0]           cnt_ctlmis
);
    logic [W-1:0] resolved, br_mis, ctl_mis, mis, drop;

    for (genvar i = 0; i < W; i++) begin : g_slot
        ebr_slot_eval #(.PCW(PCW), .DISPW(DISPW)) u_eval (
            .pc       (dec_pc[i]),
            .ctrl     (dec_ctrl[i]),
            .direct   (dec_direct[i]),
            .uncond   (dec_uncond[i]),
            .ptaken   (dec_ptaken[i]),
            .ptarg    (dec_ptarg[i]),
            .disp     (dec_disp[i]),
            .resolved (resolved[i]),
            .npc      (out_npc[i]),
            .br_mis   (br_mis[i]),
            .ctl_mis  (ctl_mis[i])
        );
        assign mis[i] = dec_vld[i] & (br_mis[i] | ctl_mis[i]);
    end

    // a slot is dropped when an earlier slot of its thread mispredicted
    always_comb begin
        for (int i = 0; i < W; i++) begin
            drop[i] = 1'b0;
            for (int j = 0; j < i; j++)
                if (mis[j] && dec_tid[j] == dec_tid[i])
                    drop[i] = 1'b1;
        end
    end
    assign out_vld = dec_vld & ~drop;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [W-1:0] hit;
        always_comb
            for (int i = 0; i < W; i++)
                hit[i] = out_vld[i] & mis[i] & (dec_tid[i] == TIDW'(t));

        ebr_thread_ctl #(.W(W), .PCW(PCW), .SEQW(SEQW)) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit),
            .hit_ctl    (ctl_mis),
            .seq        (dec_seq),
            .pc         (dec_pc),
            .npc        (out_npc),
            .stall      (thr_stall[t]),
            .skid_empty (thr_skid_empty[t]),
            .rd_vld     (rd_vld[t]),
            .rd_ctl_mis (rd_ctl_mis[t]),
            .rd_seq     (rd_seq[t]),
            .rd_npc     (rd_npc[t]),
            .rd_taken   (rd_taken[t]),
            .flush      (thr_flush[t]),
            .unblock    (thr_unblock[t]),
            .state      (thr_state[t])
        );
    end

    ebr_fetch_kill #(.FW(FW), .NTHR(NTHR), .TIDW(TIDW), .SEQW(SEQW)) u_kill (
        .fq_vld  (fq_vld),
        .fq_tid  (fq_tid),
        .fq_seq  (fq_seq),
        .rd_vld  (rd_vld),
        .rd_seq  (rd_seq),
        .fq_kill (fq_kill)
    );

    logic [CNTW-1:0] inc_res, inc_br, inc_ctl;
    always_comb begin
        inc_res = '0;
        inc_br  = '0;
        inc_ctl = '0;
        for (int i = 0; i < W; i++)
            if (out_vld[i] && resolved[i])
                inc_res = inc_res + CNTW'(1);
        for (int t = 0; t < NTHR; t++) begin
            if (rd_vld[t] && !rd_ctl_mis[t])
                inc_br = inc_br + CNTW'(1);
            if (rd_vld[t] && rd_ctl_mis[t])
                inc_ctl = inc_ctl + CNTW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_resolved <= '0;
            cnt_brmis    <= '0;
            cnt_ctlmis   <= '0;
        end else begin
            cnt_resolved <= cnt_resolved + inc_res;
            cnt_brmis    <= cnt_brmis + inc_br;
            cnt_ctlmis   <= cnt_ctlmis + inc_ctl;
        end
    end
endmodule

// File: rtl/early_branch_resolver_chk.sv
module early_branch_resolver_chk #(
    parameter int W    = 4,
    parameter int FW   = 4,
    parameter int NTHR = 2,
    parameter int TIDW = 1,
    parameter int CNTW = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [W-1:0]            dec_vld,
    input logic [W-1:0]            out_vld,
    input logic [FW-1:0]           fq_vld,
    input logic [FW-1:0][TIDW-1:0] fq_tid,
    input logic [FW-1:0]           fq_kill,
    input logic [NTHR-1:0]         rd_vld,
    input logic [NTHR-1:0]         thr_stall,
    input logic [NTHR-1:0]         thr_unblock,
    input logic [NTHR-1:0][1:0]    thr_state,
    input logic [CNTW-1:0]         cnt_brmis,
    input logic [CNTW-1:0]         cnt_ctlmis
);
    // R6
    fwd_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld & ~dec_vld) == '0);

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld == '0) |=> ($stable(cnt_brmis) && $stable(cnt_ctlmis)));

    for (genvar k = 0; k < FW; k++) begin : g_fq
        // R7
        kill_needs_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fq_kill[k] |-> (fq_vld[k] && rd_vld[fq_tid[k]]));
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_t
        // R9
        squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_vld[t] |=> (thr_state[t] == 2'd3));
        // R9
        unblock_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            thr_unblock[t] |-> rd_vld[t]);
        // R10
        blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 2'd1 && thr_stall[t] && !rd_vld[t]) |=> (thr_state[t] == 2'd1));
    end
endmodule

bind early_branch_resolver early_branch_resolver_chk #(
    .W(W), .FW(FW), .NTHR(NTHR), .TIDW(TIDW), .CNTW(CNTW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_vld     (dec_vld),
    .out_vld     (out_vld),
    .fq_vld      (fq_vld),
    .fq_tid      (fq_tid),
    .fq_kill     (fq_kill),
    .rd_vld      (rd_vld),
    .thr_stall   (thr_stall),
    .thr_unblock (thr_unblock),
    .thr_state   (thr_state),
    .cnt_brmis   (cnt_brmis),
    .cnt_ctlmis  (cnt_ctlmis)
);

// File: tb/tb_early_branch_resolver.sv
module tb_early_branch_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4, FW = 4, NTHR = 2, TIDW = 1;
    localparam int NCYC = 3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] dec_vld, dec_ctrl, dec_direct, dec_uncond, dec_ptaken;
    logic [W-1:0][TIDW-1:0] dec_tid;
    logic [W-1:0][15:0] dec_seq, dec_disp;
    logic [W-1:0][31:0] dec_pc, dec_ptarg;
    logic [FW-1:0] fq_vld;
    logic [FW-1:0][TIDW-1:0] fq_tid;
    logic [FW-1:0][15:0] fq_seq;
    logic [NTHR-1:0] thr_stall, thr_skid_empty;
    logic [W-1:0] out_vld;
    logic [W-1:0][31:0] out_npc;
    logic [NTHR-1:0] rd_vld, rd_ctl_mis, rd_taken, thr_flush, thr_unblock;
    logic [NTHR-1:0][15:0] rd_seq;
    logic [NTHR-1:0][31:0] rd_npc;
    logic [FW-1:0] fq_kill;
    logic [NTHR-1:0][1:0] thr_state;
    logic [15:0] cnt_resolved, cnt_brmis, cnt_ctlmis;

    early_branch_resolver dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // reference state
    int ref_st[NTHR];
    int ref_res = 0, ref_br = 0, ref_ctl = 0;
    bit [W-1:0] e_vld;
    logic [31:0] e_npc[W];
    bit e_rd[NTHR], e_ctl[NTHR], e_tk[NTHR], e_unb[NTHR];
    logic [15:0] e_seq[NTHR];
    logic [31:0] e_rnpc[NTHR];
    bit [FW-1:0] e_kill;
    logic [15:0] seq_base = 16'hFF00;

    task automatic drive(input bool_clean);
        for (int i = 0; i < W; i++) begin
            int d = int'($urandom % 128) - 64;
            int kind = int'($urandom % 8);
            logic [31:0] pc = {$urandom} & 32'hFFFF_FFFC;
            logic [31:0] tgt = pc + 32'(d * 4);
            dec_vld[i] = ($urandom % 4) != 0;
            dec_tid[i] = TIDW'($urandom % NTHR);
            dec_seq[i] = seq_base + 16'(i);
            dec_pc[i] = pc;
            dec_disp[i] = 16'(d);
            dec_ctrl[i] = 0; dec_direct[i] = 0; dec_uncond[i] = 0;
            dec_ptaken[i] = 0; dec_ptarg[i] = {$urandom} & 32'hFFFF_FFFC;
            if (kind < 3) begin
                dec_ctrl[i] = 1; dec_direct[i] = 1; dec_uncond[i] = 1;
                dec_ptaken[i] = bool_clean ? 1'b1 : (($urandom % 6) != 0);
                dec_ptarg[i] = (bool_clean || ($urandom % 3) != 0) ? tgt : tgt + 32'd8;
            end else if (kind == 3) begin
                dec_ctrl[i] = 1; dec_direct[i] = 1; dec_ptaken[i] = $urandom % 2;
            end else if (kind == 4) begin
                dec_ctrl[i] = 1; dec_uncond[i] = 1; dec_ptaken[i] = 1;
            end else if (kind == 5 && !bool_clean) begin
                dec_ptaken[i] = 1;
            end
        end
        for (int k = 0; k < FW; k++) begin
            fq_vld[k] = ($urandom % 4) != 0;
            fq_tid[k] = TIDW'($urandom % NTHR);
            fq_seq[k] = seq_base + 16'(int'($urandom % 17) - 6);
        end
        for (int t = 0; t < NTHR; t++) begin
            if (($urandom % 6) == 0) thr_stall[t] = ~thr_stall[t];
            thr_skid_empty[t] = ($urandom % 3) == 0;
        end
        seq_base = seq_base + 16'(W);
    endtask

    task automatic model;
        bit done[NTHR];
        for (int t = 0; t < NTHR; t++) begin
            done[t] = 0; e_rd[t] = 0; e_ctl[t] = 0; e_tk[t] = 0; e_unb[t] = 0;
            e_seq[t] = 0; e_rnpc[t] = 0;
        end
        for (int i = 0; i < W; i++) begin
            logic [31:0] fall = dec_pc[i] + 32'd4;
            logic [31:0] pred = dec_ptaken[i] ? dec_ptarg[i] : fall;
            logic [31:0] tgt = dec_pc[i] + 32'(int'($signed(dec_disp[i])) * 4);
            bit res = dec_ctrl[i] && dec_direct[i] && dec_uncond[i];
            bit cm = dec_ptaken[i] && !dec_ctrl[i];
            bit bm = res && (tgt != pred);
            int t = int'(dec_tid[i]);
            e_npc[i] = res ? tgt : (cm ? fall : pred);
            e_vld[i] = dec_vld[i] && !done[t];
            if (e_vld[i] && res) ref_res++;
            if (e_vld[i] && (cm || bm)) begin
                done[t] = 1; e_rd[t] = 1; e_ctl[t] = cm;
                e_seq[t] = dec_seq[i]; e_rnpc[t] = e_npc[i];
                e_tk[t] = e_npc[i] != fall;
                if (cm) ref_ctl++; else ref_br++;
            end
        end
        for (int k = 0; k < FW; k++) begin
            int t = int'(fq_tid[k]);
            logic signed [15:0] df = $signed(fq_seq[k] - e_seq[t]);
            e_kill[k] = fq_vld[k] && e_rd[t] && (df > 0);
        end
        for (int t = 0; t < NTHR; t++) begin
            int s = ref_st[t];
            e_unb[t] = e_rd[t] && (s == 1 || s == 2);
            if (e_rd[t]) ref_st[t] = 3;
            else if (thr_stall[t]) ref_st[t] = 1;
            else if (s == 0 || s == 3) ref_st[t] = 0;
            else ref_st[t] = thr_skid_empty[t] ? 0 : 2;
        end
    endtask

    task automatic compare_comb;
        chk(out_vld == e_vld, "R6 forward mask", 64'(out_vld), 64'(e_vld));
        for (int i = 0; i < W; i++)
            if (e_vld[i]) chk(out_npc[i] == e_npc[i], "R2 next pc", 64'(out_npc[i]), 64'(e_npc[i]));
        for (int t = 0; t < NTHR; t++) begin
            chk(rd_vld[t] == e_rd[t], "R3 redirect valid", 64'(rd_vld[t]), 64'(e_rd[t]));
            chk(thr_flush[t] == e_rd[t], "R8 flush", 64'(thr_flush[t]), 64'(e_rd[t]));
            chk(thr_unblock[t] == e_unb[t], "R9 unblock", 64'(thr_unblock[t]), 64'(e_unb[t]));
            if (e_rd[t]) begin
                chk(rd_seq[t] == e_seq[t], "R3 redirect seq", 64'(rd_seq[t]), 64'(e_seq[t]));
                chk(rd_npc[t] == e_rnpc[t], "R3 redirect npc", 64'(rd_npc[t]), 64'(e_rnpc[t]));
                chk(rd_taken[t] == e_tk[t], "R4 taken bit", 64'(rd_taken[t]), 64'(e_tk[t]));
                chk(rd_ctl_mis[t] == e_ctl[t], "R5 control mispredict", 64'(rd_ctl_mis[t]), 64'(e_ctl[t]));
            end
        end
        chk(fq_kill == e_kill, "R7 fetch kill", 64'(fq_kill), 64'(e_kill));
    endtask

    task automatic compare_regs(input string tag);
        for (int t = 0; t < NTHR; t++)
            chk(int'(thr_state[t]) == ref_st[t], {tag, " state"}, 64'(thr_state[t]), 64'(ref_st[t]));
        chk(cnt_resolved == 16'(ref_res), "R11 resolved count", 64'(cnt_resolved), 64'(16'(ref_res)));
        chk(cnt_brmis == 16'(ref_br), "R11 jump mispredict count", 64'(cnt_brmis), 64'(16'(ref_br)));
        chk(cnt_ctlmis == 16'(ref_ctl), "R11 control mispredict count", 64'(cnt_ctlmis), 64'(16'(ref_ctl)));
    endtask

    initial begin
        dec_vld = '0; dec_ctrl = '0; dec_direct = '0; dec_uncond = '0; dec_ptaken = '0;
        dec_tid = '0; dec_seq = '0; dec_disp = '0; dec_pc = '0; dec_ptarg = '0;
        fq_vld = '0; fq_tid = '0; fq_seq = '0; thr_stall = '0; thr_skid_empty = '1;
        for (int t = 0; t < NTHR; t++) ref_st[t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state with idle inputs
        compare_regs("R1");
        chk(rd_vld == '0 && thr_flush == '0 && thr_unblock == '0 && fq_kill == '0,
            "R1 idle outputs", 64'({rd_vld, thr_flush, thr_unblock, fq_kill}), 64'(0));
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            compare_regs("R10");
            drive(c < 400);
            #1;
            model();
            compare_comb();
        end
        @(negedge clk);
        compare_regs("R10");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule